// File: doc/BRIEF.md
# SDRAM Row/Column Access Sequencer

This block converts a single read or write request into the command stream needed by a four-bank SDRAM with 8192 rows and 512 columns per bank. A flat request address is split into bank, row and column fields. The block opens the row with an ACTIVE command and waits a programmable row-to-column delay. It then issues READ or WRITE with the starting column. The burst is always run in full-page mode and is cut with BURST TERMINATE once the requested number of beats has gone by. For each request, the caller picks how the row is closed: the auto-precharge flag is set on the column command, or an explicit single-bank PRECHARGE follows the terminate.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the row-precharge delay of that access has fully elapsed, so only one access is in flight at a time. A requester that holds `req_valid` high while `req_ready` is low is stalled: its fields are not looked at until the edge on which it is accepted. Refresh, the data path and analog timing belong to other blocks.

Top module: `sdram_access_seq`

## Requirements
- R1: The request address is split as bank = `req_addr[23:22]`, row = `req_addr[21:9]` and column = `req_addr[8:0]`.
- R2: In the clock cycle after acceptance, the command bus carries ACTIVE ({cs,ras,cas,we} = 0011), with the bank on `mem_ba` and the row on `mem_a`.
- R3: The column command follows exactly TRCD clocks after ACTIVE, with NOPs in between. It is READ (0101) or WRITE (0100), with BA = bank, A[8:0] = column, A10 = the auto-close choice, and all other A bits zero.
- R4: BURST TERMINATE (0110, BA and A zero) follows exactly `req_len_m1`+1 clocks after the column command. This covers any length from 1 to 512.
- R5: With explicit close (`req_auto_close` = 0), PRECHARGE (0010) is issued one clock after BURST TERMINATE, with BA = bank and A10 low (single bank), all other A bits zero.
- R6: With auto close (`req_auto_close` = 1), no PRECHARGE is issued for the access, and the cycle after BURST TERMINATE is a NOP.
- R7: `req_ready` is high in idle and falls in the cycle after acceptance. It rises again exactly TRP clocks after the close cycle (the cycle after BURST TERMINATE). Every row is therefore closed before the next ACTIVE, including a new row in the same bank.
- R8: Request fields are sampled only at acceptance, and changing them while busy has no effect on the commands. A request held valid while `req_ready` is low is accepted on the first edge at which `req_ready` is high.
- R9: During and right after reset, `req_ready` is high and the bus shows NOP with `mem_ba` and `mem_a` zero.
- R10: Every cycle without a command is a NOP (0111) with `mem_ba` and `mem_a` zero, and chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Flat address {bank, row, column} |
| req_len_m1 | input | 9 | Beat count minus one (0..511 for 1..512 beats) |
| req_auto_close | input | 1 | 1 = auto precharge, 0 = explicit PRECHARGE |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank address |
| mem_a | output | 13 | Row / column / control address |

## Verification
The sequence is driven with four request shapes:
- A one-beat read with auto close at the all-zero address shows the shortest burst, and shows that no PRECHARGE is sent.
- A four-beat write with explicit close at the all-ones address checks the field boundaries of the address split.
- A 512-beat read confirms that the terminate count reaches the full page.
- A write followed by a read to another row of the same bank is presented while the sequencer is still busy. This checks that the stalled request is taken exactly when the first row's precharge delay ends.

Request fields are scrambled after every acceptance, so any late sampling shows up as a wrong command.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_WR  = 4'b0100,
    CMD_PRE = 4'b0010,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCD,
    ST_BURST,
    ST_CLOSE,
    ST_RP
  } seq_state_e;

endpackage

// File: rtl/seq_addr_split.sv
module seq_addr_split #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col
);
  assign col  = addr[COL_W-1:0];
  assign row  = addr[COL_W +: ROW_W];
  assign bank = addr[ADDR_W-1 -: BANK_W];
endmodule

// File: rtl/seq_countdown.sv
module seq_countdown #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             is_zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign is_zero = (cnt == '0);
endmodule

// File: rtl/seq_cmd_reg.sv
module seq_cmd_reg
  import sdram_seq_pkg::*;
#(
  parameter int BA_W = 2,
  parameter int A_W  = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  sdr_cmd_e        nxt_cmd,
  input  logic [BA_W-1:0] nxt_ba,
  input  logic [A_W-1:0]  nxt_a,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic [BA_W-1:0] ba,
  output logic [A_W-1:0]  a
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
      ba <= '0;
      a  <= '0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= nxt_cmd;
      ba <= nxt_ba;
      a  <= nxt_a;
    end
  end
endmodule

// File: rtl/sdram_access_seq.sv
module sdram_access_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 9,
  parameter int TRCD   = 3,
  parameter int TRP    = 3,
  parameter int AP_BIT = 10,
  localparam int ADDR_W = BANK_W + ROW_W + COL_W,
  localparam int A_W    = ROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [COL_W-1:0]  req_len_m1,
  input  logic              req_auto_close,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BANK_W-1:0] mem_ba,
  output logic [A_W-1:0]    mem_a
);
  localparam int T_MAX = (TRCD > TRP) ? TRCD : TRP;
  localparam int T_W   = $clog2(T_MAX + 1);
  localparam int CNT_W = (T_W > COL_W) ? T_W : COL_W;

  seq_state_e        state, nxt_state;
  logic              wr_q, auto_q;
  logic [BANK_W-1:0] bank_q, in_bank;
  logic [ROW_W-1:0]  in_row;
  logic [COL_W-1:0]  col_q, in_col, len_q;
  logic              accept;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  sdr_cmd_e          nxt_cmd;
  logic [BANK_W-1:0] nxt_ba;
  logic [A_W-1:0]    nxt_a;

  seq_addr_split #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr (req_addr),
    .bank (in_bank),
    .row  (in_row),
    .col  (in_col)
  );

  seq_countdown #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .is_zero  (tmr_zero)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      wr_q   <= 1'b0;
      auto_q <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
      len_q  <= '0;
    end else begin
      state <= nxt_state;
      if (accept) begin
        wr_q   <= req_write;
        auto_q <= req_auto_close;
        bank_q <= in_bank;
        col_q  <= in_col;
        len_q  <= req_len_m1;
      end
    end
  end

  always_comb begin
    nxt_state = state;
    nxt_cmd   = CMD_NOP;
    nxt_ba    = '0;
    nxt_a     = '0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          nxt_cmd   = CMD_ACT;
          nxt_ba    = in_bank;
          nxt_a     = in_row;
          nxt_state = ST_RCD;
          tmr_load  = 1'b1;
          tmr_val   = CNT_W'(TRCD - 1);
        end
      end
      ST_RCD: begin
        if (tmr_zero) begin
          nxt_cmd              = wr_q ? CMD_WR : CMD_RD;
          nxt_ba               = bank_q;
          nxt_a[COL_W-1:0]     = col_q;
          nxt_a[AP_BIT]        = auto_q;
          nxt_state            = ST_BURST;
          tmr_load             = 1'b1;
          tmr_val              = CNT_W'(len_q);
        end
      end
      ST_BURST: begin
        if (tmr_zero) begin
          nxt_cmd   = CMD_BST;
          nxt_state = ST_CLOSE;
        end
      end
      ST_CLOSE: begin
        if (!auto_q) begin
          nxt_cmd = CMD_PRE;
          nxt_ba  = bank_q;
        end
        nxt_state = ST_RP;
        tmr_load  = 1'b1;
        tmr_val   = CNT_W'(TRP - 1);
      end
      ST_RP: begin
        if (tmr_zero) nxt_state = ST_IDLE;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  seq_cmd_reg #(.BA_W(BANK_W), .A_W(A_W)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .nxt_cmd (nxt_cmd),
    .nxt_ba  (nxt_ba),
    .nxt_a   (nxt_a),
    .cs_n    (mem_cs_n),
    .ras_n   (mem_ras_n),
    .cas_n   (mem_cas_n),
    .we_n    (mem_we_n),
    .ba      (mem_ba),
    .a       (mem_a)
  );

endmodule

// File: rtl/sdram_access_seq_chk.sv
module sdram_access_seq_chk #(
  parameter int BANK_W = 2,
  parameter int A_W    = 13,
  parameter int TRCD   = 3,
  parameter int AP_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] ba,
  input logic [A_W-1:0]    a
);
  logic [3:0]        cmd;
  logic              is_act, is_rw, is_pre;
  logic [15:0]       since_act;
  logic              auto_open;
  logic [BANK_W-1:0] act_bank;

  assign cmd    = {cs_n, ras_n, cas_n, we_n};
  assign is_act = (cmd == 4'b0011);
  assign is_rw  = (cmd == 4'b0101) || (cmd == 4'b0100);
  assign is_pre = (cmd == 4'b0010);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= 16'hFFFF;
      auto_open <= 1'b0;
      act_bank  <= '0;
    end else begin
      if (is_act) begin
        since_act <= 16'd1;
        act_bank  <= ba;
        auto_open <= 1'b0;
      end else begin
        if (since_act != 16'hFFFF) since_act <= since_act + 16'd1;
        if (is_rw) auto_open <= a[AP_BIT];
      end
    end
  end

  AST_ACCEPT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> is_act); // R2

  AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (since_act == 16'(TRCD))); // R3

  AST_PRE_SAME_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (ba == act_bank && !a[AP_BIT])); // R5

  AST_NO_PRE_AFTER_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> !auto_open); // R6

  AST_BUSY_DURING_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !req_ready); // R7

  AST_CHIP_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n); // R10

endmodule

bind sdram_access_seq sdram_access_seq_chk #(
  .BANK_W (BANK_W),
  .A_W    (A_W),
  .TRCD   (TRCD),
  .AP_BIT (AP_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cs_n      (mem_cs_n),
  .ras_n     (mem_ras_n),
  .cas_n     (mem_cas_n),
  .we_n      (mem_we_n),
  .ba        (mem_ba),
  .a         (mem_a)
);

// File: tb/sim_sdram_access_seq.sv
`timescale 1ns/1ps
module sim_sdram_access_seq;
  localparam int TRCD = 3;
  localparam int TRP  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [8:0]  req_len_m1 = '0;
  logic        req_auto_close = 1'b0;
  logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [1:0]  mem_ba;
  logic [12:0] mem_a;

  always #2.5 clk = ~clk;

  sdram_access_seq #(.TRCD(TRCD), .TRP(TRP)) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_len_m1     (req_len_m1),
    .req_auto_close (req_auto_close),
    .mem_cs_n       (mem_cs_n),
    .mem_ras_n      (mem_ras_n),
    .mem_cas_n      (mem_cas_n),
    .mem_we_n       (mem_we_n),
    .mem_ba         (mem_ba),
    .mem_a          (mem_a)
  );

  typedef struct {
    int          cyc;
    logic [3:0]  code;
    logic [1:0]  ba;
    logic [12:0] a;
    string       tag;
  } item_t;

  item_t expq[$];
  item_t mon_e;
  int    cyc = 0;
  int    compared = 0;
  int    mismatched = 0;
  int    last_rdy = 0;
  bit    pending = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, bit ok, string what, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  // monitor: compare every command against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0111) begin
        check("R10", (mem_ba == 2'd0) && (mem_a == 13'd0), "NOP address lines",
              {mem_ba, mem_a}, 0);
      end else if (expq.size() == 0) begin
        check("R6", 1'b0, "unexpected command",
              {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, 4'b0111);
      end else begin
        mon_e = expq.pop_front();
        compared++;
        if (cyc != mon_e.cyc || {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} != mon_e.code ||
            mem_ba != mon_e.ba || mem_a != mon_e.a) begin
          mismatched++;
          $display("FAIL %s: actual cyc %0d cmd %b ba %0d a %0h expected cyc %0d cmd %b ba %0d a %0h",
                   mon_e.tag, cyc, {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, mem_ba, mem_a,
                   mon_e.cyc, mon_e.code, mon_e.ba, mon_e.a);
        end
      end
    end
  end

  // driver: present a request, push the expected commands once accepted
  task automatic issue(bit wr, logic [1:0] bank, logic [12:0] row, logic [8:0] col,
                       logic [8:0] lm1, bit ap);
    int n, t_act, t_rw, t_bst, t_cls;
    bit waited;
    item_t it;
    req_valid      = 1'b1;
    req_write      = wr;
    req_addr       = {bank, row, col};   // R1
    req_len_m1     = lm1;
    req_auto_close = ap;
    waited = !req_ready;
    while (!req_ready) @(negedge clk);
    n = cyc;
    if (pending && waited)
      check("R8", n == last_rdy, "stalled request accept cycle", n, last_rdy);
    t_act = n + 1;
    t_rw  = t_act + TRCD;
    t_bst = t_rw + int'(lm1) + 1;
    t_cls = t_bst + 1;
    it.cyc = t_act; it.code = 4'b0011; it.ba = bank; it.a = row; it.tag = "R2 ACTIVE";
    expq.push_back(it);
    it.cyc = t_rw; it.code = wr ? 4'b0100 : 4'b0101; it.ba = bank;
    it.a = {2'b00, ap, 1'b0, col}; it.tag = "R3 column command";
    expq.push_back(it);
    it.cyc = t_bst; it.code = 4'b0110; it.ba = 2'd0; it.a = 13'd0; it.tag = "R4 terminate";
    expq.push_back(it);
    if (!ap) begin
      it.cyc = t_cls; it.code = 4'b0010; it.ba = bank; it.a = 13'd0; it.tag = "R5 precharge";
      expq.push_back(it);
    end
    last_rdy = t_cls + TRP;
    pending  = 1'b1;
    @(negedge clk);
    check("R7", req_ready == 1'b0, "ready after accept", req_ready, 0);
    req_valid      = 1'b0;
    req_write      = ~wr;             // R8: scrambled while busy
    req_addr       = ~{bank, row, col};
    req_len_m1     = ~lm1;
    req_auto_close = ~ap;
  endtask

  task automatic finish_wait();
    while (!req_ready) @(negedge clk);
    check("R7", cyc == last_rdy, "ready return cycle", cyc, last_rdy);
    pending = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9", req_ready == 1'b1, "ready in reset", req_ready, 1);
    check("R9", {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0111, "cmd in reset",
          {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, 4'b0111);
    check("R9", mem_ba == 2'd0 && mem_a == 13'd0, "address in reset", {mem_ba, mem_a}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", req_ready == 1'b1, "ready after reset", req_ready, 1);

    // one-beat read, auto close, all-zero address (R1 R4 R6)
    issue(1'b0, 2'd0, 13'd0, 9'd0, 9'd0, 1'b1);
    finish_wait();
    // four-beat write, explicit close, all-ones address (R1 R5)
    issue(1'b1, 2'd3, 13'h1FFF, 9'h1FF, 9'd3, 1'b0);
    finish_wait();
    // full-page read, explicit close (R4)
    issue(1'b0, 2'd2, 13'h0A5A, 9'h0F0, 9'd511, 1'b0);
    finish_wait();
    // auto-close write, then stalled read to another row of the same bank (R7 R8)
    issue(1'b1, 2'd1, 13'h1234, 9'd300, 9'd6, 1'b1);
    issue(1'b0, 2'd1, 13'h0001, 9'd5, 9'd2, 1'b0);
    finish_wait();

    repeat (6) @(negedge clk);
    done = 1'b1;
    check("R6", expq.size() == 0, "commands left unseen", expq.size(), 0);
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule